// File: doc/BRIEF.md
# RV32 Integer ALU with Multiply

This block computes one 32-bit result from two 32-bit operands and a 4-bit operation code. It serves the execute stage of a simple RV32 core. It covers the base register-register integer operations: wrapping add and subtract, bitwise xor/or/and, logical left and right shifts, arithmetic right shift and signed set-less-than. It also covers three multiply forms from the M extension and a code that passes the second operand straight through.

The operation codes are not numbered in sequence, and three codes are unused. All operations are evaluated in parallel by an adder/subtractor, a barrel shifter and a full-width multiplier, and the result is then selected. The result is held in an output register with a synchronous active-high reset, so it appears one clock after its operands and code are presented.

Top module: `int_alu_mul`

## Requirements
- R1: While `rst` is high at a rising edge, `result` becomes 0. Otherwise `result` shows, after each rising edge, the value computed from `op_sel`, `opnd_a` and `opnd_b` as sampled at that edge.
- R2: Code 0 gives `opnd_a + opnd_b` and code 12 gives `opnd_a - opnd_b`, both modulo 2^32.
- R3: Code 4 gives the bitwise xor, code 6 the bitwise or and code 7 the bitwise and of the operands.
- R4: Code 1 shifts `opnd_a` left, code 5 shifts it right filling with zeros, and code 13 shifts it right replicating bit 31. The shift amount is `opnd_b[4:0]`, and `opnd_b[31:5]` has no effect on the result.
- R5: Code 2 gives 1 when `opnd_a` is less than `opnd_b` as two's-complement numbers, and 0 otherwise. Bits 31:1 of the result are always 0.
- R6: Code 8 gives bits 31:0 of the product `opnd_a * opnd_b`.
- R7: Code 9 gives bits 63:32 of the signed-by-signed 64-bit product.
- R8: Code 11 gives bits 63:32 of the unsigned-by-unsigned 64-bit product.
- R9: Code 15 gives `opnd_b` unchanged.
- R10: Codes 3, 10 and 14 give a result of 0 whatever the operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the result register loads on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the result register |
| op_sel | input | 4 | Operation code |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand; also the shift amount source |
| result | output | 32 | Registered operation result |

## Verification
The checker assumes that `op_sel`, `opnd_a` and `opnd_b` are stable and free of unknown bits across each rising edge. Its one-cycle relations between sampled inputs and the registered result only hold under that assumption. The bench meets it by changing every input on the falling edge and sampling `result` on the falling edge that follows the loading edge. Its operand sets cover all sixteen codes against a grid of corner values, a sweep of every shift amount with the upper bits of `opnd_b` set, and pseudo-random pairs.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_SLL   = 4'd1,
    OP_SLT   = 4'd2,
    OP_XOR   = 4'd4,
    OP_SRL   = 4'd5,
    OP_OR    = 4'd6,
    OP_AND   = 4'd7,
    OP_MUL   = 4'd8,
    OP_MULH  = 4'd9,
    OP_MULHU = 4'd11,
    OP_SUB   = 4'd12,
    OP_SRA   = 4'd13,
    OP_PASSB = 4'd15
  } alu_op_e;

endpackage

// File: rtl/int_alu_addsub.sv
module int_alu_addsub #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic            subtract,
  output logic [XLEN-1:0] sum,
  output logic            less_signed
);
  localparam int MSB = XLEN - 1;

  logic [XLEN-1:0] b_eff;

  always_comb begin
    b_eff = subtract ? ~b : b;
    sum   = a + b_eff + {{(XLEN-1){1'b0}}, subtract};
    // Operands of differing sign decide by sign alone; otherwise the
    // difference cannot overflow and its sign answers.
    if (a[MSB] != b[MSB]) less_signed = a[MSB];
    else                  less_signed = sum[MSB];
  end
endmodule

// File: rtl/int_alu_shift.sv
module int_alu_shift #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0]         data,
  input  logic [$clog2(XLEN)-1:0] amount,
  input  logic                    to_left,
  input  logic                    arith,
  output logic [XLEN-1:0]         shifted
);
  localparam int SHW = $clog2(XLEN);

  logic [XLEN-1:0] flipped_in;
  logic [XLEN-1:0] stage [0:SHW];
  logic            fill;

  // A left shift is a right shift of the bit-reversed word.
  genvar gi;
  generate
    for (gi = 0; gi < XLEN; gi++) begin : g_rev_in
      assign flipped_in[gi] = data[XLEN-1-gi];
    end
  endgenerate

  assign fill     = arith & ~to_left & data[XLEN-1];
  assign stage[0] = to_left ? flipped_in : data;

  genvar gs;
  generate
    for (gs = 0; gs < SHW; gs++) begin : g_stage
      localparam int STEP = 1 << gs;
      assign stage[gs+1] = amount[gs]
        ? {{STEP{fill}}, stage[gs][XLEN-1:STEP]}
        : stage[gs];
    end
  endgenerate

  logic [XLEN-1:0] flipped_out;
  generate
    for (gi = 0; gi < XLEN; gi++) begin : g_rev_out
      assign flipped_out[gi] = stage[SHW][XLEN-1-gi];
    end
  endgenerate

  assign shifted = to_left ? flipped_out : stage[SHW];
endmodule

// File: rtl/int_alu_mult.sv
module int_alu_mult #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic            signed_ops,
  output logic [XLEN-1:0] prod_lo,
  output logic [XLEN-1:0] prod_hi
);
  localparam int PW = 2 * XLEN;

  logic [PW-1:0] a_wide;
  logic [PW-1:0] b_wide;
  logic [PW-1:0] prod;

  // Widening with sign or zero, then keeping the product modulo 2^PW,
  // gives the exact two's-complement or unsigned double-width product.
  always_comb begin
    a_wide  = {{XLEN{signed_ops & a[XLEN-1]}}, a};
    b_wide  = {{XLEN{signed_ops & b[XLEN-1]}}, b};
    prod    = a_wide * b_wide;
    prod_lo = prod[XLEN-1:0];
    prod_hi = prod[PW-1:XLEN];
  end
endmodule

// File: rtl/int_alu_mul.sv
module int_alu_mul
  import int_alu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [3:0]      op_sel,
  input  logic [XLEN-1:0] opnd_a,
  input  logic [XLEN-1:0] opnd_b,
  output logic [XLEN-1:0] result
);
  localparam int SHW = $clog2(XLEN);

  alu_op_e         op;
  logic [XLEN-1:0] sum;
  logic            lt;
  logic [XLEN-1:0] sh_out;
  logic [XLEN-1:0] m_lo;
  logic [XLEN-1:0] m_hi;
  logic [XLEN-1:0] next_res;

  assign op = alu_op_e'(op_sel);

  int_alu_addsub #(.XLEN(XLEN)) u_addsub (
    .a           (opnd_a),
    .b           (opnd_b),
    .subtract    (op == OP_SUB || op == OP_SLT),
    .sum         (sum),
    .less_signed (lt)
  );

  int_alu_shift #(.XLEN(XLEN)) u_shift (
    .data    (opnd_a),
    .amount  (opnd_b[SHW-1:0]),
    .to_left (op == OP_SLL),
    .arith   (op == OP_SRA),
    .shifted (sh_out)
  );

  int_alu_mult #(.XLEN(XLEN)) u_mult (
    .a          (opnd_a),
    .b          (opnd_b),
    .signed_ops (op == OP_MULH),
    .prod_lo    (m_lo),
    .prod_hi    (m_hi)
  );

  always_comb begin
    unique case (op)
      OP_ADD, OP_SUB:          next_res = sum;
      OP_SLL, OP_SRL, OP_SRA:  next_res = sh_out;
      OP_SLT:                  next_res = {{(XLEN-1){1'b0}}, lt};
      OP_XOR:                  next_res = opnd_a ^ opnd_b;
      OP_OR:                   next_res = opnd_a | opnd_b;
      OP_AND:                  next_res = opnd_a & opnd_b;
      OP_MUL:                  next_res = m_lo;
      OP_MULH, OP_MULHU:       next_res = m_hi;
      OP_PASSB:                next_res = opnd_b;
      default:                 next_res = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) result <= '0;
    else     result <= next_res;
  end
endmodule

// File: rtl/int_alu_mul_chk.sv
module int_alu_mul_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic [3:0]      op_sel,
  input logic [XLEN-1:0] opnd_a,
  input logic [XLEN-1:0] opnd_b,
  input logic [XLEN-1:0] result
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> result == '0);

  a_r2_add_wraps: assert property (@(posedge clk) disable iff (rst)
    op_sel == 4'd0 |=> result == $past(opnd_a) + $past(opnd_b));

  a_r2_sub_wraps: assert property (@(posedge clk) disable iff (rst)
    op_sel == 4'd12 |=> result == $past(opnd_a) - $past(opnd_b));

  a_r3_xor: assert property (@(posedge clk) disable iff (rst)
    op_sel == 4'd4 |=> result == ($past(opnd_a) ^ $past(opnd_b)));

  a_r5_slt_one_bit: assert property (@(posedge clk) disable iff (rst)
    op_sel == 4'd2 |=> result[XLEN-1:1] == '0);

  a_r9_pass_b: assert property (@(posedge clk) disable iff (rst)
    op_sel == 4'd15 |=> result == $past(opnd_b));

  a_r10_unused_zero: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 4'd3 || op_sel == 4'd10 || op_sel == 4'd14) |=> result == '0);
endmodule

bind int_alu_mul int_alu_mul_chk #(.XLEN(XLEN)) i_chk (
  .clk    (clk),
  .rst    (rst),
  .op_sel (op_sel),
  .opnd_a (opnd_a),
  .opnd_b (opnd_b),
  .result (result)
);

// File: tb/test_int_alu_mul.sv
module test_int_alu_mul;
  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  op_sel;
  logic [31:0] opnd_a;
  logic [31:0] opnd_b;
  logic [31:0] result;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;  // 250 MHz

  int_alu_mul #(.XLEN(32)) i_int_alu_mul (
    .clk    (clk),
    .rst    (rst),
    .op_sel (op_sel),
    .opnd_a (opnd_a),
    .opnd_b (opnd_b),
    .result (result)
  );

  function automatic string req_of(input logic [3:0] s);
    case (s)
      4'd0, 4'd12:         return "R2";
      4'd4, 4'd6, 4'd7:    return "R3";
      4'd1, 4'd5, 4'd13:   return "R4";
      4'd2:                return "R5";
      4'd8:                return "R6";
      4'd9:                return "R7";
      4'd11:               return "R8";
      4'd15:               return "R9";
      default:             return "R10";
    endcase
  endfunction

  function automatic logic [31:0] model(input logic [3:0] s,
                                        input logic [31:0] x,
                                        input logic [31:0] y);
    logic [63:0] p;
    logic [4:0]  n;
    n = y[4:0];
    case (s)
      4'd0:  return x + y;
      4'd1:  return x << n;
      4'd2:  return ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
      4'd4:  return x ^ y;
      4'd5:  return x >> n;
      4'd6:  return x | y;
      4'd7:  return x & y;
      4'd8:  begin p = {32'd0, x} * {32'd0, y}; return p[31:0]; end
      4'd9:  begin
               p = $signed({{32{x[31]}}, x}) * $signed({{32{y[31]}}, y});
               return p[63:32];
             end
      4'd11: begin p = {32'd0, x} * {32'd0, y}; return p[63:32]; end
      4'd12: return x - y;
      4'd13: return $signed(x) >>> n;
      4'd15: return y;
      default: return 32'd0;
    endcase
  endfunction

  task automatic run(input logic [3:0] s, input logic [31:0] x, input logic [31:0] y);
    logic [31:0] exp;
    @(negedge clk);
    op_sel = s; opnd_a = x; opnd_b = y;
    @(negedge clk);
    exp = model(s, x, y);
    checks++;
    if (result !== exp) begin
      errors++;
      $display("FAIL %s op=%0d a=%h b=%h actual=%h expected=%h",
               req_of(s), s, x, y, result, exp);
    end
  endtask

  task automatic expect_val(input string tag, input logic [31:0] exp);
    checks++;
    if (result !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, result, exp);
    end
  endtask

  logic [31:0] corners [0:7];

  initial begin
    corners[0] = 32'h0000_0000; corners[1] = 32'h0000_0001;
    corners[2] = 32'hFFFF_FFFF; corners[3] = 32'h8000_0000;
    corners[4] = 32'h7FFF_FFFF; corners[5] = 32'h0000_001F;
    corners[6] = 32'h1234_5678; corners[7] = 32'hFFFF_FFE1;

    rst = 1'b1; op_sel = 4'd15; opnd_a = 32'hDEAD_BEEF; opnd_b = 32'hCAFE_F00D;
    @(negedge clk); @(negedge clk);
    expect_val("R1 reset", 32'd0);
    rst = 1'b0;
    @(negedge clk);
    expect_val("R1 first load", 32'hCAFE_F00D);
    op_sel = 4'd0; rst = 1'b1;
    @(negedge clk);
    expect_val("R1 reset overrides", 32'd0);
    rst = 1'b0;

    // Exhaustive over codes and corner operand grid
    for (int s = 0; s < 16; s++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          run(4'(s), corners[i], corners[j]);

    // R4: every amount, with upper bits of B set
    for (int n = 0; n < 32; n++) begin
      run(4'd1,  32'h8765_4321, {27'h5A5A5A5, 5'(n)});
      run(4'd5,  32'h8765_4321, {27'h7FFFFFF, 5'(n)});
      run(4'd13, 32'h8765_4321, {27'h4000001, 5'(n)});
      run(4'd13, 32'h7654_3210, {27'h0000020, 5'(n)});
    end

    // R5: operands differing only in the top bit
    run(4'd2, 32'h8000_0005, 32'h0000_0005);
    run(4'd2, 32'h0000_0005, 32'h8000_0005);

    // R7/R8 corner: most negative squared
    run(4'd9,  32'h8000_0000, 32'h8000_0000);
    run(4'd11, 32'h8000_0000, 32'h8000_0000);

    // Pseudo-random pairs for every code
    for (int k = 0; k < 60; k++)
      for (int s = 0; s < 16; s++)
        run(4'(s), $urandom, $urandom);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule